// File: doc/BRIEF.md
# Burst SRAM Cycle Control Decoder

This block is the synchronous control front end of a pipelined burst SRAM. On every rising clock edge it samples three chip selects, two address strobes (one driven by a processor, one by a memory controller), a burst-advance input, per-byte write enables with a byte-write qualifier and a global write, and a sleep request. From these it classifies the cycle and registers the result. The registered outputs are a 3-bit cycle code, a load pulse and an advance pulse for the burst address counter, and a write strobe for the array.

A data-bus drive enable is formed from the registered cycle type and the output-enable input. The output-enable path is purely combinational, so the bus releases as soon as output enable rises. The two strobes are deliberately asymmetric. The processor strobe always opens a read and is gated by the first chip select. The controller strobe can open either a read or a write, and only it can start a write. After a sleep request falls, the block recovers over a fixed number of cycles.

Top module: `burst_sram_ctrl`

## Requirements
- R1: The effective write is active when `gwr_n` is 0, or when `bwr_n` is 0 and at least one bit of `byte_en_n` is 0. In every other case the cycle is treated as a read.
- R2: With `sel_a_n` = 1 and `ctl_stb_n` = 0, the next cycle code is 0 (deselect), and load, advance and write strobe are all 0. Under `sel_a_n` = 1, the state of `cpu_stb_n` has no effect on this result.
- R3: When either strobe opens a cycle with `sel_a_n` = 0 but with `sel_b` = 0 or `sel_c_n` = 1, the code is 0 (deselect) and no load, advance or write strobe is issued.
- R4: With `cpu_stb_n` = 0 and all selects active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0), the code is 2 (begin read) with `burst_load` = 1 and `wr_strobe` = 0, whatever the write enables are.
- R5: With `cpu_stb_n` = 1, `ctl_stb_n` = 0 and all selects active, `burst_load` is 1. The code is 3 (begin write) with `wr_strobe` = 1 when the effective write is active, and 2 otherwise.
- R6: With `ctl_stb_n` = 1, with either `cpu_stb_n` = 1 or `sel_a_n` = 1, and with `adv_n` = 0, `burst_adv` is 1. The code is 5 (continue write) with `wr_strobe` = 1 when the effective write is active, and 4 (continue read) otherwise.
- R7: Under the same strobe conditions as R6 but with `adv_n` = 1, the code is 6 (suspend), load and advance are both 0, and `wr_strobe` equals the effective write.
- R8: A sleep request sampled high gives code 1 with load, advance and write strobe at 0, regardless of every other input. After the request is sampled low, code 1 persists for exactly two more edges.
- R9: `bus_drive` is 1 only while the registered cycle is a read (code 2, code 4, or code 6 without write) and `oe_n` is 0. It follows `oe_n` without waiting for a clock edge, and it is never 1 in a write, deselect or sleep cycle.
- R10: After reset the code is 0 and `burst_load`, `burst_adv`, `wr_strobe` and `bus_drive` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a_n | input | 1 | First chip select, active low; gates the processor strobe |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| byte_en_n | input | NUM_BYTES | Per-byte write enables, active low |
| bwr_n | input | 1 | Byte-write qualifier, active low |
| gwr_n | input | 1 | Global write, active low |
| sleep_req | input | 1 | Sleep request, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| cycle_code | output | 3 | Registered cycle type code |
| burst_load | output | 1 | Load external address into the burst counter |
| burst_adv | output | 1 | Advance the burst counter |
| wr_strobe | output | 1 | Registered array write strobe |
| bus_drive | output | 1 | Data bus drive enable |

## Verification
The riskiest overlap is between a processor strobe and a write request in the same cycle: R4 has to win over R5, so write enables that are asserted while the processor strobe is low must never produce a write strobe. The bench provokes this by sweeping every combination of strobes, selects, advance and write enables, and it checks the registered code and strobes one edge later against an arithmetic model. A second overlap is between output enable and a write or sleep cycle. Here `oe_n` is toggled low and high inside each registered cycle, and `bus_drive` must stay 0 unless the cycle is a read.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [2:0] {
        CYC_DESEL    = 3'd0,
        CYC_SLEEP    = 3'd1,
        CYC_BEGIN_RD = 3'd2,
        CYC_BEGIN_WR = 3'd3,
        CYC_CONT_RD  = 3'd4,
        CYC_CONT_WR  = 3'd5,
        CYC_SUSPEND  = 3'd6
    } cyc_e;

    typedef struct packed {
        cyc_e code;
        logic load;
        logic adv;
        logic wr;
        logic rd;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{code: CYC_DESEL, load: 1'b0, adv: 1'b0, wr: 1'b0, rd: 1'b0};

    function automatic ctrl_t mk_ctrl(cyc_e c, logic ld, logic av, logic w, logic r);
        ctrl_t t;
        t.code = c;
        t.load = ld;
        t.adv  = av;
        t.wr   = w;
        t.rd   = r;
        return t;
    endfunction

endpackage

// File: rtl/bsc_write_reduce.sv
module bsc_write_reduce #(
    parameter int NUM_BYTES = 4
) (
    input  logic [NUM_BYTES-1:0] byte_en_n,
    input  logic                 bwr_n,
    input  logic                 gwr_n,
    output logic                 eff_write
);
    logic any_byte;

    always_comb begin
        any_byte = 1'b0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            any_byte = any_byte | ~byte_en_n[i];
        end
        eff_write = ~gwr_n | (~bwr_n & any_byte);
    end
endmodule

// File: rtl/bsc_sleep_ctrl.sv
module bsc_sleep_ctrl #(
    parameter int WAKE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    output logic in_sleep
);
    localparam int CW = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES + 1);

    logic [CW-1:0] wake_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_cnt <= '0;
        end else if (sleep_req) begin
            wake_cnt <= CW'(WAKE_CYCLES);
        end else if (wake_cnt != '0) begin
            wake_cnt <= wake_cnt - 1'b1;
        end
    end

    assign in_sleep = sleep_req | (wake_cnt != '0);
endmodule

// File: rtl/bsc_cycle_decode.sv
module bsc_cycle_decode
    import bsc_pkg::*;
(
    input  logic  in_sleep,
    input  logic  sel_a_n,
    input  logic  sel_b,
    input  logic  sel_c_n,
    input  logic  cpu_stb_n,
    input  logic  ctl_stb_n,
    input  logic  adv_n,
    input  logic  eff_write,
    output ctrl_t nxt
);
    logic selected;
    logic cpu_start;

    always_comb begin
        selected  = ~sel_a_n & sel_b & ~sel_c_n;
        cpu_start = ~cpu_stb_n & ~sel_a_n;
        nxt       = CTRL_IDLE;

        if (in_sleep) begin
            nxt = mk_ctrl(CYC_SLEEP, 1'b0, 1'b0, 1'b0, 1'b0);
        end else if (cpu_start) begin
            if (selected) nxt = mk_ctrl(CYC_BEGIN_RD, 1'b1, 1'b0, 1'b0, 1'b1);
            else          nxt = CTRL_IDLE;
        end else if (!ctl_stb_n) begin
            if (!selected)      nxt = CTRL_IDLE;
            else if (eff_write) nxt = mk_ctrl(CYC_BEGIN_WR, 1'b1, 1'b0, 1'b1, 1'b0);
            else                nxt = mk_ctrl(CYC_BEGIN_RD, 1'b1, 1'b0, 1'b0, 1'b1);
        end else if (!adv_n) begin
            if (eff_write) nxt = mk_ctrl(CYC_CONT_WR, 1'b0, 1'b1, 1'b1, 1'b0);
            else           nxt = mk_ctrl(CYC_CONT_RD, 1'b0, 1'b1, 1'b0, 1'b1);
        end else begin
            nxt = mk_ctrl(CYC_SUSPEND, 1'b0, 1'b0, eff_write, ~eff_write);
        end
    end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import bsc_pkg::*;
#(
    parameter int NUM_BYTES   = 4,
    parameter int WAKE_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_a_n,
    input  logic                 sel_b,
    input  logic                 sel_c_n,
    input  logic                 cpu_stb_n,
    input  logic                 ctl_stb_n,
    input  logic                 adv_n,
    input  logic [NUM_BYTES-1:0] byte_en_n,
    input  logic                 bwr_n,
    input  logic                 gwr_n,
    input  logic                 sleep_req,
    input  logic                 oe_n,
    output logic [2:0]           cycle_code,
    output logic                 burst_load,
    output logic                 burst_adv,
    output logic                 wr_strobe,
    output logic                 bus_drive
);
    logic  eff_write;
    logic  in_sleep;
    ctrl_t nxt;
    ctrl_t cur;

    bsc_write_reduce #(.NUM_BYTES(NUM_BYTES)) u_wr (
        .byte_en_n (byte_en_n),
        .bwr_n     (bwr_n),
        .gwr_n     (gwr_n),
        .eff_write (eff_write)
    );

    bsc_sleep_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) u_sleep (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .in_sleep  (in_sleep)
    );

    bsc_cycle_decode u_dec (
        .in_sleep  (in_sleep),
        .sel_a_n   (sel_a_n),
        .sel_b     (sel_b),
        .sel_c_n   (sel_c_n),
        .cpu_stb_n (cpu_stb_n),
        .ctl_stb_n (ctl_stb_n),
        .adv_n     (adv_n),
        .eff_write (eff_write),
        .nxt       (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) cur <= CTRL_IDLE;
        else     cur <= nxt;
    end

    assign cycle_code = cur.code;
    assign burst_load = cur.load;
    assign burst_adv  = cur.adv;
    assign wr_strobe  = cur.wr;
    assign bus_drive  = cur.rd & ~oe_n;
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker (
    input logic       clk,
    input logic       rst,
    input logic       sel_a_n,
    input logic       cpu_stb_n,
    input logic       ctl_stb_n,
    input logic       sleep_req,
    input logic       oe_n,
    input logic [2:0] cycle_code,
    input logic       burst_load,
    input logic       burst_adv,
    input logic       wr_strobe,
    input logic       bus_drive
);
    // R4: processor strobe under the first select never leads to a write
    assert_cpu_read_only_R4: assert property (@(posedge clk) disable iff (rst)
        (!cpu_stb_n && !sel_a_n) |=> !wr_strobe);

    // R2: unselected controller strobe gives nothing
    assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (sel_a_n && !ctl_stb_n) |=> (!burst_load && !burst_adv && !wr_strobe));

    // R8: sleep request forces the sleep code next edge
    assert_sleep_code_R8: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> (cycle_code == 3'd1 && !burst_load && !burst_adv && !wr_strobe));

    // R9: bus driven only with output enable low and never during a write
    assert_bus_gate_R9: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> (!oe_n && !wr_strobe && cycle_code != 3'd1 && cycle_code != 3'd0));

    // R6: load and advance never together
    assert_load_adv_excl_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({burst_load, burst_adv}));
endmodule

bind burst_sram_ctrl bsc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_a_n    (sel_a_n),
    .cpu_stb_n  (cpu_stb_n),
    .ctl_stb_n  (ctl_stb_n),
    .sleep_req  (sleep_req),
    .oe_n       (oe_n),
    .cycle_code (cycle_code),
    .burst_load (burst_load),
    .burst_adv  (burst_adv),
    .wr_strobe  (wr_strobe),
    .bus_drive  (bus_drive)
);

// File: tb/burst_sram_ctrl_test.sv
`timescale 1ns/1ps
module burst_sram_ctrl_test;
    localparam int NB = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic cpu_stb_n = 1'b1, ctl_stb_n = 1'b1, adv_n = 1'b1;
    logic [NB-1:0] byte_en_n = '1;
    logic bwr_n = 1'b1, gwr_n = 1'b1, sleep_req = 1'b0, oe_n = 1'b1;
    logic [2:0] cycle_code;
    logic burst_load, burst_adv, wr_strobe, bus_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    burst_sram_ctrl #(.NUM_BYTES(NB), .WAKE_CYCLES(2)) uut (
        .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
        .byte_en_n(byte_en_n), .bwr_n(bwr_n), .gwr_n(gwr_n), .sleep_req(sleep_req),
        .oe_n(oe_n), .cycle_code(cycle_code), .burst_load(burst_load),
        .burst_adv(burst_adv), .wr_strobe(wr_strobe), .bus_drive(bus_drive)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int ew, code, ld, av, wr, rd;
        string tag;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        chk("R10 code", cycle_code, 0);
        chk("R10 load", burst_load, 0);
        chk("R10 adv", burst_adv, 0);
        chk("R10 wr", wr_strobe, 0);
        oe_n = 1'b0; #0.5;
        chk("R10 bus", bus_drive, 0);
        oe_n = 1'b1;

        // Exhaustive sweep: 10 input bits
        for (int v = 0; v < 1024; v++) begin
            @(negedge clk);
            {sel_a_n, sel_b, sel_c_n, cpu_stb_n, ctl_stb_n, adv_n, bwr_n, gwr_n, byte_en_n} = v[9:0];
            oe_n = 1'b1;
            // R1 effective write
            ew = (!gwr_n || (!bwr_n && (byte_en_n != '1))) ? 1 : 0;
            ld = 0; av = 0; wr = 0; rd = 0;
            if (!cpu_stb_n && !sel_a_n) begin
                tag = "R4";
                if (sel_b && !sel_c_n) begin code = 2; ld = 1; rd = 1; end
                else begin code = 0; tag = "R3"; end
            end else if (!ctl_stb_n) begin
                tag = "R5";
                if (sel_a_n) begin code = 0; tag = "R2"; end
                else if (!(sel_b && !sel_c_n)) begin code = 0; tag = "R3"; end
                else if (ew == 1) begin code = 3; ld = 1; wr = 1; tag = "R1_R5"; end
                else begin code = 2; ld = 1; rd = 1; end
            end else if (!adv_n) begin
                tag = "R6";
                if (ew == 1) begin code = 5; av = 1; wr = 1; end
                else begin code = 4; av = 1; rd = 1; end
            end else begin
                tag = "R7";
                code = 6; wr = ew; rd = 1 - ew;
            end
            step();
            chk({tag, " code"}, cycle_code, code);
            chk({tag, " load"}, burst_load, ld);
            chk({tag, " adv"}, burst_adv, av);
            chk({tag, " wr"}, wr_strobe, wr);
            chk("R9 bus oe high", bus_drive, 0);
            oe_n = 1'b0; #0.5;
            chk("R9 bus oe low", bus_drive, rd);
            oe_n = 1'b1; #0.5;
            chk("R9 bus release", bus_drive, 0);
        end

        // R8 sleep: all inputs set for a write start, sleep overrides
        @(negedge clk);
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        cpu_stb_n = 1'b1; ctl_stb_n = 1'b0; gwr_n = 1'b0; adv_n = 1'b1;
        sleep_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R8 sleep code", cycle_code, 1);
            chk("R8 sleep load", burst_load, 0);
            chk("R8 sleep wr", wr_strobe, 0);
            @(negedge clk);
        end
        // read start under sleep, bus must stay off
        gwr_n = 1'b1;
        step();
        oe_n = 1'b0; #0.5;
        chk("R8 sleep bus", bus_drive, 0);
        oe_n = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        step();
        chk("R8 recover edge 1", cycle_code, 1);
        @(negedge clk);
        step();
        chk("R8 recover edge 2", cycle_code, 1);
        @(negedge clk);
        step();
        chk("R8 awake begin read", cycle_code, 2);
        chk("R8 awake load", burst_load, 1);

        // R10 reset in mid-write
        @(negedge clk);
        gwr_n = 1'b0;
        step();
        chk("R5 pre-reset write", wr_strobe, 1);
        @(negedge clk);
        rst = 1'b1;
        step();
        chk("R10 reset code", cycle_code, 0);
        chk("R10 reset wr", wr_strobe, 0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule